// File: doc/BRIEF.md
# I2C Master End-of-Byte Sequencer

This block closes each byte of an I2C master transfer. After a received byte it drives the acknowledge slot: either an acknowledge (SDA held low) or a not-acknowledge (SDA left released) for one SCL pulse. It can also end the transfer with a stop condition, in which SDA rises while SCL is high. A reloadable down-counter sets every phase of both sequences. SCL and SDA are open-drain. The block drives each line only through a drive-low enable and reads each line back through a two-flop synchronizer. A slave that holds SCL low therefore stretches the clock: the counter does not run while the sequencer waits for a released line to read high.

Software starts a sequence with a one-cycle go strobe and watches a busy bit for that sequence. The busy bit clears itself when the sequence ends. The block also holds a one-byte transmit buffer. Completion raises an interrupt flag, and a finished stop also raises a stop-seen flag. A buffer write made while a sequence runs is dropped and raises a collision flag. All three flags stay set until a clear strobe.

Top module: `i2c_endseq`

## Requirements
- R1: After reset both drive-low outputs are 0, both busy bits are 0, the interrupt, stop-seen and collision flags are 0, and the buffer reads 0.
- R2: An acknowledge go accepted in idle makes the acknowledge busy bit 1 on the next cycle, with SCL driven low and SDA driven low exactly when the acknowledge data bit was 0.
- R3: SCL is driven low for reload+1 cycles and then released. When the synchronized SCL reads high, SCL is released for reload+1 more cycles. It is then driven low again and held low in idle until a stop. The busy bit clears and the interrupt flag sets. The counter does not move while the sequencer waits for SCL.
- R4: A stop go accepted in idle drives SDA low while SCL stays low. Once the synchronized SDA reads low, SCL stays low for reload+1 more cycles and is then released.
- R5: SDA is released reload+1 cycles after the synchronized SCL reads high. The stop-seen flag sets when the synchronized SDA and SCL both read high.
- R6: Reload+1 cycles after the stop-seen flag sets, the stop busy bit clears, the interrupt flag sets, and both lines are released.
- R7: A buffer write in idle loads the buffer. A buffer write while either sequence is busy sets the collision flag and leaves the buffer unchanged.
- R8: The interrupt, stop-seen and collision flags stay set until the clear strobe. If a set and the clear arrive in the same cycle, the set wins.
- R9: A go strobe that arrives while a sequence is busy is ignored. If both go strobes arrive together in idle, the acknowledge sequence starts and the stop request is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reloadVal | input | CNT_W | Reload value of the phase counter |
| ackGo | input | 1 | Strobe that starts the acknowledge sequence |
| ackBit | input | 1 | Acknowledge data: 0 acknowledge, 1 not-acknowledge |
| stopGo | input | 1 | Strobe that starts the stop sequence |
| bufWr | input | 1 | Transmit buffer write strobe |
| bufData | input | DATA_W | Transmit buffer write data |
| clrFlags | input | 1 | Clears the interrupt, stop-seen and collision flags |
| sclIn | input | 1 | SCL line level |
| sdaIn | input | 1 | SDA line level |
| sclDrvLow | output | 1 | Drive SCL low when 1 |
| sdaDrvLow | output | 1 | Drive SDA low when 1 |
| ackBusy | output | 1 | Acknowledge sequence active |
| stopBusy | output | 1 | Stop sequence active |
| stopSeen | output | 1 | Stop observed on the bus (sticky) |
| irqFlag | output | 1 | Sequence complete (sticky) |
| wcolFlag | output | 1 | Buffer write collision (sticky) |
| bufOut | output | DATA_W | Transmit buffer contents |

## Verification
The bench models a slave that holds SCL low for a random number of cycles each time the master releases it. A design that let the counter run during this stretch would release or drop SCL early, and the per-cycle compare would flag it. The reload value is swept down to zero to catch a counter that is off by one, since such a design would shift every line edge by one cycle. Buffer writes, clear strobes and go strobes are also sent while a sequence is running and in the same cycle as a flag set. A design that took those writes, dropped a flag on a clear, or started a second sequence would then differ from the model in buffer contents, flag state or busy bits.

// File: rtl/i2c_endseq_pkg.sv
package i2c_endseq_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_ACK_LOW, S_ACK_WAIT, S_ACK_HIGH,
    S_STP_SDA, S_STP_CNT, S_STP_SCLW, S_STP_SCLH, S_STP_SDAW, S_STP_FIN
  } seqState_t;

  typedef struct packed {
    logic cntLoad;
    logic cntRun;
    logic setIrq;
    logic setStop;
    logic busy;
  } seqStrobe_t;
endpackage

// File: rtl/i2c_endseq_ctrl.sv
module i2c_endseq_ctrl
  import i2c_endseq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       ackGo,
  input  logic       ackBit,
  input  logic       stopGo,
  input  logic       sclS,
  input  logic       sdaS,
  input  logic       cntDone,
  output seqStrobe_t strb,
  output logic       sclDrvLow,
  output logic       sdaDrvLow,
  output logic       ackBusy,
  output logic       stopBusy
);
  seqState_t state, nxt;
  logic ackBitL, sclHold;

  always_comb begin
    nxt  = state;
    strb = '0;
    strb.busy = (state != S_IDLE);
    unique case (state)
      S_IDLE: begin
        if (ackGo) begin
          nxt = S_ACK_LOW;
          strb.cntLoad = 1'b1;
        end else if (stopGo) begin
          nxt = S_STP_SDA;
        end
      end
      S_ACK_LOW: begin
        strb.cntRun = 1'b1;
        if (cntDone) nxt = S_ACK_WAIT;
      end
      S_ACK_WAIT: begin
        if (sclS) begin
          nxt = S_ACK_HIGH;
          strb.cntLoad = 1'b1;
        end
      end
      S_ACK_HIGH: begin
        strb.cntRun = 1'b1;
        if (cntDone) begin
          nxt = S_IDLE;
          strb.setIrq = 1'b1;
        end
      end
      S_STP_SDA: begin
        if (!sdaS) begin
          nxt = S_STP_CNT;
          strb.cntLoad = 1'b1;
        end
      end
      S_STP_CNT: begin
        strb.cntRun = 1'b1;
        if (cntDone) nxt = S_STP_SCLW;
      end
      S_STP_SCLW: begin
        if (sclS) begin
          nxt = S_STP_SCLH;
          strb.cntLoad = 1'b1;
        end
      end
      S_STP_SCLH: begin
        strb.cntRun = 1'b1;
        if (cntDone) nxt = S_STP_SDAW;
      end
      S_STP_SDAW: begin
        if (sclS && sdaS) begin
          nxt = S_STP_FIN;
          strb.cntLoad = 1'b1;
          strb.setStop = 1'b1;
        end
      end
      S_STP_FIN: begin
        strb.cntRun = 1'b1;
        if (cntDone) begin
          nxt = S_IDLE;
          strb.setIrq = 1'b1;
        end
      end
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      ackBitL <= 1'b0;
      sclHold <= 1'b0;
    end else begin
      state <= nxt;
      if (state == S_IDLE && ackGo) ackBitL <= ackBit;
      if (state == S_ACK_HIGH && cntDone) sclHold <= 1'b1;
      if (state == S_STP_FIN && cntDone) sclHold <= 1'b0;
    end
  end

  assign ackBusy  = (state == S_ACK_LOW) || (state == S_ACK_WAIT) || (state == S_ACK_HIGH);
  assign stopBusy = (state != S_IDLE) && !ackBusy;
  assign sclDrvLow = (state == S_ACK_LOW) || (state == S_STP_SDA) || (state == S_STP_CNT)
                   || (state == S_IDLE && sclHold);
  assign sdaDrvLow = (ackBusy && !ackBitL) || (state == S_STP_SDA) || (state == S_STP_CNT)
                   || (state == S_STP_SCLW) || (state == S_STP_SCLH);

  // R2: acknowledge start drives the lines from the data bit
  p_ack_start_r2: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_IDLE && ackGo) |=> (ackBusy && sclDrvLow && (sdaDrvLow == !$past(ackBit))));

  // R4: stop start pulls SDA low with SCL low
  p_stop_start_r4: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_IDLE && stopGo && !ackGo) |=> (stopBusy && sdaDrvLow && sclDrvLow));

  // R9: go while busy does not start the other sequence
  p_ignore_go_r9: assert property (@(posedge clk) disable iff (!rstN)
    (stopBusy && ackGo) |=> !ackBusy);
endmodule

// File: rtl/i2c_endseq_dp.sv
module i2c_endseq_dp
  import i2c_endseq_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int DATA_W = 8,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strb,
  input  logic [CNT_W-1:0]  reloadVal,
  input  logic              bufWr,
  input  logic [DATA_W-1:0] bufData,
  input  logic              clrFlags,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sclS,
  output logic              sdaS,
  output logic              cntDone,
  output logic              stopSeen,
  output logic              irqFlag,
  output logic              wcolFlag,
  output logic [DATA_W-1:0] bufOut
);
  localparam logic [CNT_W-1:0] CNT_ZERO = '0;

  logic [SYNC_N-1:0] sclSync, sdaSync;
  logic [CNT_W-1:0]  cnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSync <= '1;
      sdaSync <= '1;
    end else begin
      sclSync <= {sclSync[SYNC_N-2:0], sclIn};
      sdaSync <= {sdaSync[SYNC_N-2:0], sdaIn};
    end
  end
  assign sclS = sclSync[SYNC_N-1];
  assign sdaS = sdaSync[SYNC_N-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cnt <= CNT_ZERO;
    else if (strb.cntLoad) cnt <= reloadVal;
    else if (strb.cntRun && cnt != CNT_ZERO) cnt <= cnt - 1'b1;
  end
  assign cntDone = (cnt == CNT_ZERO);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqFlag  <= 1'b0;
      stopSeen <= 1'b0;
      wcolFlag <= 1'b0;
      bufOut   <= '0;
    end else begin
      if (strb.setIrq) irqFlag <= 1'b1;
      else if (clrFlags) irqFlag <= 1'b0;
      if (strb.setStop) stopSeen <= 1'b1;
      else if (clrFlags) stopSeen <= 1'b0;
      if (bufWr && strb.busy) wcolFlag <= 1'b1;
      else if (clrFlags) wcolFlag <= 1'b0;
      if (bufWr && !strb.busy) bufOut <= bufData;
    end
  end

  // R3: counter frozen while neither loading nor running
  p_cnt_frozen_r3: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.cntLoad || strb.cntRun) |=> $stable(cnt));

  // R7: busy write flags collision and keeps the buffer
  p_wcol_r7: assert property (@(posedge clk) disable iff (!rstN)
    (bufWr && strb.busy) |=> (wcolFlag && $stable(bufOut)));

  // R8: interrupt flag sticky without clear
  p_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    (irqFlag && !clrFlags) |=> irqFlag);

  // R5: stop-seen only set with both lines sampled high
  p_stopseen_r5: assert property (@(posedge clk) disable iff (!rstN)
    strb.setStop |-> (sclS && sdaS));
endmodule

// File: rtl/i2c_endseq.sv
module i2c_endseq
  import i2c_endseq_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CNT_W-1:0]  reloadVal,
  input  logic              ackGo,
  input  logic              ackBit,
  input  logic              stopGo,
  input  logic              bufWr,
  input  logic [DATA_W-1:0] bufData,
  input  logic              clrFlags,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sclDrvLow,
  output logic              sdaDrvLow,
  output logic              ackBusy,
  output logic              stopBusy,
  output logic              stopSeen,
  output logic              irqFlag,
  output logic              wcolFlag,
  output logic [DATA_W-1:0] bufOut
);
  seqStrobe_t strb;
  logic sclS, sdaS, cntDone;

  i2c_endseq_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .ackGo(ackGo), .ackBit(ackBit), .stopGo(stopGo),
    .sclS(sclS), .sdaS(sdaS), .cntDone(cntDone), .strb(strb),
    .sclDrvLow(sclDrvLow), .sdaDrvLow(sdaDrvLow),
    .ackBusy(ackBusy), .stopBusy(stopBusy)
  );

  i2c_endseq_dp #(.CNT_W(CNT_W), .DATA_W(DATA_W), .SYNC_N(2)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .reloadVal(reloadVal),
    .bufWr(bufWr), .bufData(bufData), .clrFlags(clrFlags),
    .sclIn(sclIn), .sdaIn(sdaIn), .sclS(sclS), .sdaS(sdaS),
    .cntDone(cntDone), .stopSeen(stopSeen), .irqFlag(irqFlag),
    .wcolFlag(wcolFlag), .bufOut(bufOut)
  );

  // R6: stop end releases both lines and raises the interrupt
  p_stop_end_r6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(stopBusy) |-> (irqFlag && !sclDrvLow && !sdaDrvLow));
endmodule

// File: tb/sim_i2c_endseq.sv
module sim_i2c_endseq;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 8;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [CW-1:0] reloadVal = 8'd3;
  logic ackGo = 0, ackBit = 0, stopGo = 0, bufWr = 0, clrFlags = 0;
  logic [DW-1:0] bufData = '0;
  logic sclIn = 1'b1, sdaIn = 1'b1;
  logic sclDrvLow, sdaDrvLow, ackBusy, stopBusy, stopSeen, irqFlag, wcolFlag;
  logic [DW-1:0] bufOut;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_endseq #(.CNT_W(CW), .DATA_W(DW)) u0 (
    .clk(clk), .rstN(rstN), .reloadVal(reloadVal), .ackGo(ackGo), .ackBit(ackBit),
    .stopGo(stopGo), .bufWr(bufWr), .bufData(bufData), .clrFlags(clrFlags),
    .sclIn(sclIn), .sdaIn(sdaIn), .sclDrvLow(sclDrvLow), .sdaDrvLow(sdaDrvLow),
    .ackBusy(ackBusy), .stopBusy(stopBusy), .stopSeen(stopSeen), .irqFlag(irqFlag),
    .wcolFlag(wcolFlag), .bufOut(bufOut)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference: phase number, counter, flags, line samplers.
  // Phases: 0 idle, 1 ack low, 2 ack wait-high, 3 ack high,
  // 4 stop sda-low wait, 5 stop count, 6 stop scl wait, 7 stop scl high,
  // 8 stop wait both high, 9 stop final.
  int ph = 0, mc = 0, mAb = 0, mHold = 0;
  int qScl[$] = '{1, 1};
  int qSda[$] = '{1, 1};
  int mIrq = 0, mStp = 0, mWcol = 0, mBuf = 0;
  int iRst = 0, iAck = 0, iBit = 0, iStop = 0, iWr = 0, iData = 0, iClr = 0;
  int iScl = 1, iSda = 1, iRel = 0;
  int stretch = 0;
  logic prevSclDrv = 1'b0;

  task automatic modelStep();
    int nph, ld, rn, sIrq, sStp, busy, sclS, sdaS, done;
    if (iRst == 0) begin
      ph = 0; mc = 0; mAb = 0; mHold = 0; mIrq = 0; mStp = 0; mWcol = 0; mBuf = 0;
      qScl = '{1, 1}; qSda = '{1, 1};
      return;
    end
    sclS = qScl[1]; sdaS = qSda[1];
    done = (mc == 0);
    nph = ph; ld = 0; rn = 0; sIrq = 0; sStp = 0;
    busy = (ph != 0);
    case (ph)
      0: if (iAck != 0) begin nph = 1; ld = 1; mAb = iBit; end
         else if (iStop != 0) nph = 4;
      1: begin rn = 1; if (done) nph = 2; end
      2: if (sclS != 0) begin nph = 3; ld = 1; end
      3: begin rn = 1; if (done) begin nph = 0; sIrq = 1; mHold = 1; end end
      4: if (sdaS == 0) begin nph = 5; ld = 1; end
      5: begin rn = 1; if (done) nph = 6; end
      6: if (sclS != 0) begin nph = 7; ld = 1; end
      7: begin rn = 1; if (done) nph = 8; end
      8: if (sclS != 0 && sdaS != 0) begin nph = 9; ld = 1; sStp = 1; end
      default: begin rn = 1; if (done) begin nph = 0; sIrq = 1; mHold = 0; end end
    endcase
    if (sIrq != 0) mIrq = 1; else if (iClr != 0) mIrq = 0;
    if (sStp != 0) mStp = 1; else if (iClr != 0) mStp = 0;
    if (iWr != 0 && busy != 0) mWcol = 1; else if (iClr != 0) mWcol = 0;
    if (iWr != 0 && busy == 0) mBuf = iData;
    if (ld != 0) mc = iRel; else if (rn != 0 && mc != 0) mc = mc - 1;
    void'(qScl.pop_back()); qScl.push_front(iScl);
    void'(qSda.pop_back()); qSda.push_front(iSda);
    ph = nph;
  endtask

  always @(negedge clk) begin
    int eScl, eSda, eAck, eStop;
    modelStep();
    eAck  = (ph >= 1 && ph <= 3) ? 1 : 0;
    eStop = (ph >= 4) ? 1 : 0;
    eScl  = (ph == 1 || ph == 4 || ph == 5 || (ph == 0 && mHold != 0)) ? 1 : 0;
    eSda  = ((eAck != 0 && mAb == 0) || (ph >= 4 && ph <= 7)) ? 1 : 0;
    chk(sclDrvLow == eScl[0], "R3 R4 scl drive", sclDrvLow, eScl);
    chk(sdaDrvLow == eSda[0], "R2 R5 sda drive", sdaDrvLow, eSda);
    chk(ackBusy == eAck[0], "R2 R9 ackBusy", ackBusy, eAck);
    chk(stopBusy == eStop[0], "R4 R6 R9 stopBusy", stopBusy, eStop);
    chk(irqFlag == mIrq[0], "R6 R8 irqFlag", irqFlag, mIrq);
    chk(stopSeen == mStp[0], "R5 R8 stopSeen", stopSeen, mStp);
    chk(wcolFlag == mWcol[0], "R7 R8 wcolFlag", wcolFlag, mWcol);
    chk(int'(bufOut) == mBuf, "R7 bufOut", bufOut, mBuf);
    // slave: stretch SCL after each master release
    if (prevSclDrv && !sclDrvLow) stretch = $urandom_range(0, 6);
    prevSclDrv = sclDrvLow;
    sclIn = !(sclDrvLow || stretch > 0);
    sdaIn = !sdaDrvLow;
    if (stretch > 0) stretch--;
    iRst = rstN; iAck = ackGo; iBit = ackBit; iStop = stopGo; iWr = bufWr;
    iData = bufData; iClr = clrFlags; iScl = sclIn; iSda = sdaIn; iRel = reloadVal;
  end

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic waitIdle();
    for (int k = 0; k < 400; k++) begin
      if (!ackBusy && !stopBusy) break;
      tick();
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finishRun();
  end

  initial begin
    repeat (3) tick();
    // R1: reset state
    chk(!sclDrvLow && !sdaDrvLow, "R1 lines released", {sclDrvLow, sdaDrvLow}, 0);
    chk(!ackBusy && !stopBusy, "R1 idle", {ackBusy, stopBusy}, 0);
    chk(!irqFlag && !stopSeen && !wcolFlag && bufOut == 0, "R1 flags clear",
        {irqFlag, stopSeen, wcolFlag}, 0);
    rstN = 1; tick();
    // R7: idle buffer write
    bufWr = 1; bufData = 8'hA5; tick(); bufWr = 0;
    chk(bufOut == 8'hA5, "R7 idle write", bufOut, 8'hA5);
    // R2: acknowledge start
    ackBit = 0; ackGo = 1; tick(); ackGo = 0;
    chk(ackBusy && sclDrvLow && sdaDrvLow, "R2 ack start", {ackBusy, sclDrvLow, sdaDrvLow}, 7);
    // R9: stop go during ack ignored
    stopGo = 1; tick(); stopGo = 0;
    chk(!stopBusy, "R9 stop ignored", stopBusy, 0);
    // R7: busy write rejected
    bufWr = 1; bufData = 8'h3C; tick(); bufWr = 0;
    chk(wcolFlag && bufOut == 8'hA5, "R7 collision", bufOut, 8'hA5);
    waitIdle();
    chk(irqFlag && sclDrvLow, "R3 ack done", {irqFlag, sclDrvLow}, 3);
    // R8: sticky then clear
    repeat (3) tick();
    chk(irqFlag && wcolFlag, "R8 sticky", {irqFlag, wcolFlag}, 3);
    clrFlags = 1; tick(); clrFlags = 0;
    chk(!irqFlag && !wcolFlag, "R8 clear", {irqFlag, wcolFlag}, 0);
    // R4..R6: stop
    stopGo = 1; tick(); stopGo = 0;
    chk(stopBusy && sdaDrvLow && sclDrvLow, "R4 stop start", {stopBusy, sdaDrvLow}, 3);
    waitIdle();
    chk(stopSeen == 1, "R5 stop seen", stopSeen, 1);
    chk(irqFlag && !sclDrvLow && !sdaDrvLow, "R6 stop done", {irqFlag, sclDrvLow, sdaDrvLow}, 4);
    // not-acknowledge with zero reload
    reloadVal = 0; clrFlags = 1; tick(); clrFlags = 0;
    ackBit = 1; ackGo = 1; tick(); ackGo = 0;
    chk(ackBusy && !sdaDrvLow, "R2 nack leaves SDA", sdaDrvLow, 0);
    waitIdle();
    // R9: simultaneous go, ack wins
    ackBit = 0; ackGo = 1; stopGo = 1; tick(); ackGo = 0; stopGo = 0;
    chk(ackBusy && !stopBusy, "R9 ack priority", {ackBusy, stopBusy}, 2);
    waitIdle();
    reloadVal = 5; stopGo = 1; tick(); stopGo = 0;
    waitIdle();
    // random traffic against the model
    for (int n = 0; n < 3000; n++) begin
      ackGo    = ($urandom_range(0, 19) == 0);
      stopGo   = ($urandom_range(0, 19) == 0);
      ackBit   = $urandom_range(0, 1);
      bufWr    = ($urandom_range(0, 7) == 0);
      bufData  = 8'($urandom_range(0, 255));
      clrFlags = ($urandom_range(0, 9) == 0);
      if ($urandom_range(0, 63) == 0) reloadVal = 8'($urandom_range(0, 4));
      tick();
    end
    ackGo = 0; stopGo = 0; bufWr = 0; clrFlags = 0;
    waitIdle();
    repeat (4) tick();
    finishRun();
  end
endmodule